// File: doc/BRIEF.md
# Strap-Configured Multi-Mode Host Port

This block is the host-facing control port of a DSP-style device. Its pins are shared between three roles: reset-time configuration straps, an 8-bit parallel host bus, and a serial (SPI slave) link. While reset is held, the three strap pins are sampled. The value present on the final reset cycle selects one protocol, and that choice stays fixed until the next reset. The protocols are an Intel-style parallel bus with separate read and write strobes, a Motorola-style parallel bus with a read/write level and a data strobe, or SPI mode 0.

Whichever protocol is active, the host sees the same four registers. These are a data register, a status register, a control register and a reserved slot. The data register reads from an outgoing FIFO that the core fills and writes to a single incoming holding register that the core drains. The core side uses plain valid/ready byte handshakes. An active-low interrupt output stays asserted while the outgoing FIFO holds unread bytes.

All host strobes, the serial clock, serial data and chip select go through two-flop synchronizers into the system clock. Every host access is carried out on a synchronized edge.

Top module: `strap_host_port`

## Requirements
- R1: The strap triple {sdo_strap_i, rd_n_rw, wr_n_ds} is captured on every cycle with rst high, and the last captured value is held until the next reset. The value 3'b001 selects SPI. Any value with bit 2 set selects the Motorola-style bus. The values 000, 010 and 011 select the Intel-style bus.
- R2: In the cycle after reset is released, the outputs are at rest: irq_n=1, bus_d_oe=0, sdo_oe=0, in_valid=0, out_ready=1 and ctrl=0.
- R3: The core pushes a byte when out_valid and out_ready are both high. The FIFO holds DEPTH bytes, and out_ready is low while it is full. A host read of address 0 returns the oldest byte and removes it. When the FIFO is empty, such a read returns 0 and removes nothing.
- R4: irq_n is 0 while the outgoing FIFO holds at least one byte. It returns to 1 once the FIFO is empty.
- R5: A host write to address 0 loads in_data and raises in_valid. in_valid stays high until the core accepts the byte with in_ready. A host write to address 0 while in_valid is high is dropped.
- R6: Address 1 reads status: bit0 means the outgoing FIFO is not empty, bit1 means the incoming register is full, and the other bits are 0. Address 2 is a read/write control byte driven on ctrl. Address 3 reads 0 and ignores writes.
- R7: In Intel mode, with cs_n low, rd_n_rw low starts a read and wr_n_ds low starts a write. Address bit 0 is on addr0_sck and address bit 1 is on addr1_sdi. bus_d_oe is high only while a read is in progress.
- R8: In Motorola mode, with cs_n low and wr_n_ds (data strobe) low, rd_n_rw high is a read and rd_n_rw low is a write.
- R9: In SPI mode 0, the frame is a command byte followed by a data byte, MSB first. Command bit 7 is 1 for read, and bits 1:0 hold the address. On a read, the data byte comes out on sdo_o. sdo_oe is 0 while cs_n is high.
- R10: In SPI mode, bus_d_oe never rises, and parallel strobes change no register.
- R11: A core push and a host pop of the FIFO in the same cycle both take effect, and the byte order is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; straps captured while high |
| cs_n | input | 1 | Active-low chip select (all modes) |
| addr0_sck | input | 1 | Address bit 0 (parallel) or serial clock (SPI) |
| addr1_sdi | input | 1 | Address bit 1 (parallel) or serial data in (SPI) |
| rd_n_rw | input | 1 | Strap bit 1; Intel read strobe or Motorola read/write level |
| wr_n_ds | input | 1 | Strap bit 0; Intel write strobe or Motorola data strobe |
| sdo_strap_i | input | 1 | Strap bit 2 input of the shared serial-out pin |
| sdo_o | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable of serial data out |
| bus_d_i | input | DATA_W | Parallel data bus, input side |
| bus_d_o | output | DATA_W | Parallel data bus, output side |
| bus_d_oe | output | 1 | Parallel data bus output enable |
| irq_n | output | 1 | Active-low outgoing-data interrupt |
| out_data | input | DATA_W | Core byte to send to host |
| out_valid | input | 1 | Core byte valid |
| out_ready | output | 1 | Outgoing FIFO can accept |
| in_data | output | DATA_W | Byte written by host |
| in_valid | output | 1 | Incoming register full |
| in_ready | input | 1 | Core accepts incoming byte |
| ctrl | output | DATA_W | Control register contents |

## Verification
The interaction that matters is a core push into the outgoing FIFO landing in the same clock edge as a host read that pops it. The bench lowers the parallel read strobe, counts the two synchronizer stages and the edge detector, and then raises out_valid for exactly the cycle in which the pop takes effect. After that access, the status register and a full drain of the FIFO must show an unchanged depth and the original byte order, with the new byte last. A second overlap is a core accept of the incoming register while the host writes address 0 again, which must leave the register empty rather than reloaded.

// File: rtl/hp_pkg.sv
package hp_pkg;

  typedef enum logic [1:0] {
    MODE_INTEL = 2'd0,
    MODE_MOTO  = 2'd1,
    MODE_SPI   = 2'd2
  } port_mode_e;

  localparam logic [1:0] REG_DATA = 2'd0;
  localparam logic [1:0] REG_STAT = 2'd1;
  localparam logic [1:0] REG_CTRL = 2'd2;
  localparam logic [1:0] REG_RSVD = 2'd3;

  // strap bits ordered {bit2, bit1, bit0}
  function automatic port_mode_e strap_decode(input logic [2:0] s);
    if (s == 3'b001)
      return MODE_SPI;
    else if (s[2])
      return MODE_MOTO;
    else
      return MODE_INTEL;
  endfunction

endpackage

// File: rtl/hp_sync.sv
module hp_sync #(
  parameter int          W      = 1,
  parameter int          STAGES = 2,
  parameter logic [W-1:0] IDLE  = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst)
        stage_q[s] <= IDLE;
      else if (s == 0)
        stage_q[s] <= d;
      else
        stage_q[s] <= stage_q[(s == 0) ? 0 : s - 1];
    end
  end

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/hp_fifo.sv
module hp_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 4,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [DW-1:0] wdata,
  input  logic          pop,
  output logic [DW-1:0] rdata,
  output logic          empty_q,
  output logic          full_q,
  output logic [CW-1:0] count_q
);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic          do_push, do_pop;
  logic [CW-1:0] cnt_nx;

  assign do_push = push & ~full_q;
  assign do_pop  = pop & ~empty_q;

  always_ff @(posedge clk) begin
    if (do_push)
      mem[wp_q] <= wdata;
  end

  assign rdata = mem[rp_q];

  always_comb begin
    cnt_nx = count_q;
    if (do_push && !do_pop)
      cnt_nx = count_q + CW'(1);
    else if (do_pop && !do_push)
      cnt_nx = count_q - CW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp_q    <= '0;
      rp_q    <= '0;
      count_q <= '0;
      empty_q <= 1'b1;
      full_q  <= 1'b0;
    end else begin
      if (do_push)
        wp_q <= (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + AW'(1);
      if (do_pop)
        rp_q <= (rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + AW'(1);
      count_q <= cnt_nx;
      empty_q <= (cnt_nx == '0);
      full_q  <= (cnt_nx == CW'(DEPTH));
    end
  end

endmodule

// File: rtl/hp_par_if.sv
module hp_par_if #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          enable,
  input  logic          moto,
  input  logic          cs_n_s,
  input  logic [1:0]    addr_s,
  input  logic          rd_rw_s,
  input  logic          wr_ds_s,
  input  logic [DW-1:0] bus_i,
  input  logic [DW-1:0] rdata,
  output logic          rd_req,
  output logic          wr_req,
  output logic [1:0]    addr,
  output logic [DW-1:0] wdata,
  output logic [DW-1:0] bus_o_q,
  output logic          bus_oe_q
);

  logic rd_act, wr_act, rd_prev_q, wr_prev_q;

  always_comb begin
    if (moto) begin
      rd_act = enable & ~cs_n_s & ~wr_ds_s &  rd_rw_s;
      wr_act = enable & ~cs_n_s & ~wr_ds_s & ~rd_rw_s;
    end else begin
      rd_act = enable & ~cs_n_s & ~rd_rw_s;
      wr_act = enable & ~cs_n_s & ~wr_ds_s & rd_rw_s;
    end
  end

  assign rd_req = rd_act & ~rd_prev_q;
  assign wr_req = wr_act & ~wr_prev_q;
  assign addr   = addr_s;
  assign wdata  = bus_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_prev_q <= 1'b0;
      wr_prev_q <= 1'b0;
      bus_oe_q  <= 1'b0;
      bus_o_q   <= '0;
    end else begin
      rd_prev_q <= rd_act;
      wr_prev_q <= wr_act;
      bus_oe_q  <= rd_act;
      if (rd_req)
        bus_o_q <= rdata;
    end
  end

endmodule

// File: rtl/hp_spi_if.sv
module hp_spi_if #(
  parameter int DW  = 8,
  localparam int FB = 2 * DW,
  localparam int CW = $clog2(FB + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          enable,
  input  logic          cs_n_s,
  input  logic          sck_s,
  input  logic          sdi_s,
  input  logic [DW-1:0] rdata,
  output logic          rd_req,
  output logic          wr_req,
  output logic [1:0]    addr,
  output logic [DW-1:0] wdata,
  output logic          sdo_o,
  output logic          sdo_oe_q
);

  logic          active, sck_prev_q, rise, fall;
  logic [CW-1:0] cnt_q;
  logic [DW-1:0] sh_in_q, sh_out_q, next_byte;
  logic          cmd_rd_q;
  logic [1:0]    addr_q;
  logic          cmd_done, data_done;

  assign active    = enable & ~cs_n_s;
  assign rise      = active &  sck_s & ~sck_prev_q;
  assign fall      = active & ~sck_s &  sck_prev_q;
  assign next_byte = {sh_in_q[DW-2:0], sdi_s};
  assign cmd_done  = rise & (cnt_q == CW'(DW - 1));
  assign data_done = rise & (cnt_q == CW'(FB - 1));

  assign rd_req = cmd_done & next_byte[DW-1];
  assign wr_req = data_done & ~cmd_rd_q;
  assign addr   = cmd_done ? next_byte[1:0] : addr_q;
  assign wdata  = next_byte;
  assign sdo_o  = sh_out_q[DW-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_prev_q <= 1'b0;
      sdo_oe_q   <= 1'b0;
    end else begin
      sck_prev_q <= sck_s;
      sdo_oe_q   <= active;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !active) begin
      cnt_q    <= '0;
      sh_in_q  <= '0;
      sh_out_q <= '0;
      cmd_rd_q <= 1'b0;
      addr_q   <= '0;
    end else begin
      if (rise) begin
        sh_in_q <= next_byte;
        if (cnt_q < CW'(FB))
          cnt_q <= cnt_q + CW'(1);
        if (cmd_done) begin
          cmd_rd_q <= next_byte[DW-1];
          addr_q   <= next_byte[1:0];
          if (next_byte[DW-1])
            sh_out_q <= rdata;
        end
      end else if (fall && cnt_q > CW'(DW)) begin
        sh_out_q <= {sh_out_q[DW-2:0], 1'b0};
      end
    end
  end

endmodule

// File: rtl/strap_host_port.sv
module strap_host_port #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 4,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              addr0_sck,
  input  logic              addr1_sdi,
  input  logic              rd_n_rw,
  input  logic              wr_n_ds,
  input  logic              sdo_strap_i,
  output logic              sdo_o,
  output logic              sdo_oe,
  input  logic [DATA_W-1:0] bus_d_i,
  output logic [DATA_W-1:0] bus_d_o,
  output logic              bus_d_oe,
  output logic              irq_n,
  input  logic [DATA_W-1:0] out_data,
  input  logic              out_valid,
  output logic              out_ready,
  output logic [DATA_W-1:0] in_data,
  output logic              in_valid,
  input  logic              in_ready,
  output logic [DATA_W-1:0] ctrl
);
  import hp_pkg::*;

  port_mode_e mode_q;
  logic [4:0] pins_s;
  logic cs_n_s, rdrw_s, wrds_s, a1_s, a0_s;

  hp_sync #(.W(5), .STAGES(2), .IDLE(5'b11100)) u_sync (
    .clk(clk), .rst(rst),
    .d({cs_n, rd_n_rw, wr_n_ds, addr1_sdi, addr0_sck}),
    .q(pins_s)
  );
  assign {cs_n_s, rdrw_s, wrds_s, a1_s, a0_s} = pins_s;

  always_ff @(posedge clk) begin
    if (rst)
      mode_q <= strap_decode({sdo_strap_i, rd_n_rw, wr_n_ds});
  end

  logic is_spi;
  assign is_spi = (mode_q == MODE_SPI);

  logic              p_rd, p_wr, s_rd, s_wr;
  logic [1:0]        p_addr, s_addr, h_addr;
  logic [DATA_W-1:0] p_wdata, s_wdata, h_wdata, h_rdata;
  logic              h_rd, h_wr;

  hp_par_if #(.DW(DATA_W)) u_par (
    .clk(clk), .rst(rst), .enable(~is_spi), .moto(mode_q == MODE_MOTO),
    .cs_n_s(cs_n_s), .addr_s({a1_s, a0_s}), .rd_rw_s(rdrw_s), .wr_ds_s(wrds_s),
    .bus_i(bus_d_i), .rdata(h_rdata), .rd_req(p_rd), .wr_req(p_wr),
    .addr(p_addr), .wdata(p_wdata), .bus_o_q(bus_d_o), .bus_oe_q(bus_d_oe)
  );

  hp_spi_if #(.DW(DATA_W)) u_spi (
    .clk(clk), .rst(rst), .enable(is_spi), .cs_n_s(cs_n_s),
    .sck_s(a0_s), .sdi_s(a1_s), .rdata(h_rdata), .rd_req(s_rd), .wr_req(s_wr),
    .addr(s_addr), .wdata(s_wdata), .sdo_o(sdo_o), .sdo_oe_q(sdo_oe)
  );

  assign h_rd    = is_spi ? s_rd : p_rd;
  assign h_wr    = is_spi ? s_wr : p_wr;
  assign h_addr  = is_spi ? s_addr : p_addr;
  assign h_wdata = is_spi ? s_wdata : p_wdata;

  // outgoing FIFO
  logic [DATA_W-1:0] fifo_head;
  logic              fifo_empty, fifo_full, fifo_pop;
  logic [CW-1:0]     fifo_cnt;

  assign fifo_pop = h_rd & (h_addr == REG_DATA);

  hp_fifo #(.DW(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .push(out_valid), .wdata(out_data), .pop(fifo_pop),
    .rdata(fifo_head), .empty_q(fifo_empty), .full_q(fifo_full), .count_q(fifo_cnt)
  );

  assign out_ready = ~fifo_full;
  assign irq_n     = fifo_empty;

  // register file
  logic              in_full_q;
  logic [DATA_W-1:0] in_q, ctrl_q;

  always_comb begin
    case (h_addr)
      REG_DATA: h_rdata = fifo_empty ? '0 : fifo_head;
      REG_STAT: h_rdata = {{(DATA_W-2){1'b0}}, in_full_q, ~fifo_empty};
      REG_CTRL: h_rdata = ctrl_q;
      default:  h_rdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      in_full_q <= 1'b0;
      in_q      <= '0;
      ctrl_q    <= '0;
    end else begin
      if (in_full_q && in_ready)
        in_full_q <= 1'b0;
      else if (h_wr && h_addr == REG_DATA && !in_full_q) begin
        in_full_q <= 1'b1;
        in_q      <= h_wdata;
      end
      if (h_wr && h_addr == REG_CTRL)
        ctrl_q <= h_wdata;
    end
  end

  assign in_valid = in_full_q;
  assign in_data  = in_q;
  assign ctrl     = ctrl_q;

endmodule

// File: rtl/strap_host_port_checks.sv
module strap_host_port_checks #(
  parameter int DEPTH = 4,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst,
  input hp_pkg::port_mode_e mode,
  input logic              bus_d_oe,
  input logic              sdo_oe,
  input logic              irq_n,
  input logic              out_valid,
  input logic              out_ready,
  input logic              in_valid,
  input logic              in_ready,
  input logic [CW-1:0]     fifo_cnt
);
  import hp_pkg::*;

  assert_mode_hold_R1: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> $stable(mode));

  assert_rest_after_reset_R2: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (irq_n && !bus_d_oe && !sdo_oe && !in_valid));

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
    fifo_cnt <= CW'(DEPTH));

  assert_push_raises_irq_R4: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready) |=> !irq_n);

  assert_in_held_R5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_ready) |=> in_valid);

  assert_sdo_only_spi_R9: assert property (@(posedge clk) disable iff (rst)
    sdo_oe |-> (mode == MODE_SPI));

  assert_bus_quiet_spi_R10: assert property (@(posedge clk) disable iff (rst)
    bus_d_oe |-> (mode != MODE_SPI));

endmodule

bind strap_host_port strap_host_port_checks #(.DEPTH(DEPTH)) u_checks (
  .clk(clk), .rst(rst), .mode(mode_q), .bus_d_oe(bus_d_oe), .sdo_oe(sdo_oe),
  .irq_n(irq_n), .out_valid(out_valid), .out_ready(out_ready),
  .in_valid(in_valid), .in_ready(in_ready), .fifo_cnt(fifo_cnt)
);

// File: tb/strap_host_port_test.sv
`timescale 1ns/1ps
module strap_host_port_test;
  localparam int DW = 8;
  localparam int DEPTH = 4;
  localparam int H = 6;

  logic clk = 0;
  always #2.5 clk = ~clk;

  logic rst = 1, cs_n = 1, addr0_sck = 0, addr1_sdi = 0, rd_n_rw = 1, wr_n_ds = 1;
  logic sdo_strap_i = 0, sdo_o, sdo_oe, bus_d_oe, irq_n, out_ready, in_valid;
  logic out_valid = 0, in_ready = 0;
  logic [DW-1:0] bus_d_i = 0, bus_d_o, in_data, ctrl, out_data = 0;

  strap_host_port #(.DATA_W(DW), .DEPTH(DEPTH)) uut (.*);

  int errs = 0, checks = 0;
  bit moto = 0;
  logic [DW-1:0] q[$];
  logic in_full_m = 0;
  logic [DW-1:0] in_m = 0, ctrl_m = 0;

  function automatic logic [DW-1:0] exp_status();
    return {6'b0, in_full_m, q.size() != 0};
  endfunction

  function automatic logic [DW-1:0] exp_read(input logic [1:0] a);
    case (a)
      2'd0: return (q.size() != 0) ? q.pop_front() : '0;
      2'd1: return exp_status();
      2'd2: return ctrl_m;
      default: return '0;
    endcase
  endfunction

  task automatic model_write(input logic [1:0] a, input logic [DW-1:0] d);
    if (a == 2'd0 && !in_full_m) begin in_full_m = 1; in_m = d; end
    if (a == 2'd2) ctrl_m = d;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [2:0] s);
    @(negedge clk);
    rst = 1; cs_n = 1; addr0_sck = 0; addr1_sdi = 0;
    wr_n_ds = s[0]; rd_n_rw = s[1]; sdo_strap_i = s[2];
    repeat (4) @(negedge clk);
    rst = 0;
    wr_n_ds = 1; rd_n_rw = 1; sdo_strap_i = 0;
    q.delete(); in_full_m = 0; in_m = 0; ctrl_m = 0;
    moto = s[2];
    repeat (4) @(negedge clk);
  endtask

  task automatic push(input logic [DW-1:0] b);
    @(negedge clk); out_valid = 1; out_data = b;
    @(negedge clk); out_valid = 0;
    if (q.size() < DEPTH) q.push_back(b);
  endtask

  task automatic par_read(input logic [1:0] a, input string req);
    logic [DW-1:0] e;
    @(negedge clk);
    addr0_sck = a[0]; addr1_sdi = a[1]; cs_n = 0;
    if (moto) begin rd_n_rw = 1; wr_n_ds = 0; end else rd_n_rw = 0;
    repeat (H) @(negedge clk);
    e = exp_read(a);
    chk(req, bus_d_o, e);
    chk({req, " oe during read"}, bus_d_oe, 1);
    cs_n = 1; rd_n_rw = 1; wr_n_ds = 1;
    repeat (H) @(negedge clk);
    chk({req, " oe after read"}, bus_d_oe, 0);
  endtask

  task automatic par_write(input logic [1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    addr0_sck = a[0]; addr1_sdi = a[1]; bus_d_i = d; cs_n = 0;
    if (moto) begin rd_n_rw = 0; wr_n_ds = 0; end else wr_n_ds = 0;
    repeat (H) @(negedge clk);
    cs_n = 1; rd_n_rw = 1; wr_n_ds = 1;
    model_write(a, d);
    repeat (H) @(negedge clk);
  endtask

  task automatic spi_xfer(input logic rd, input logic [1:0] a, input logic [DW-1:0] wd,
                          input string req);
    logic [15:0] fr;
    logic [DW-1:0] rb, e;
    fr = {rd, 5'b0, a, wd};
    rb = '0;
    @(negedge clk); cs_n = 0; addr0_sck = 0;
    repeat (4) @(negedge clk);
    chk({req, " sdo_oe in frame"}, sdo_oe, 1);
    e = rd ? exp_read(a) : '0;
    for (int i = 0; i < 16; i++) begin
      addr0_sck = 0; addr1_sdi = fr[15-i];
      repeat (H) @(negedge clk);
      if (i >= 8) rb[15-i] = sdo_o;
      addr0_sck = 1;
      repeat (H) @(negedge clk);
    end
    addr0_sck = 0;
    repeat (H) @(negedge clk);
    cs_n = 1;
    repeat (H) @(negedge clk);
    chk({req, " sdo_oe idle"}, sdo_oe, 0);
    if (rd) chk(req, rb, e);
    else model_write(a, wd);
  endtask

  initial begin
    #1ms;
    errs++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic [DW-1:0] b, nb;
    void'($urandom(32'd4411));

    // Intel mode
    do_reset(3'b000);
    chk("R2 irq_n", irq_n, 1);
    chk("R2 bus_d_oe", bus_d_oe, 0);
    chk("R2 sdo_oe", sdo_oe, 0);
    chk("R2 out_ready", out_ready, 1);
    chk("R2 in_valid", in_valid, 0);
    chk("R2 ctrl", ctrl, 0);
    par_read(2'd1, "R6 status empty");
    for (int k = 0; k < 3; k++) push(DW'($urandom));
    @(negedge clk); chk("R4 irq asserted", irq_n, 0);
    par_read(2'd1, "R6 status avail");
    for (int k = 0; k < 3; k++) par_read(2'd0, "R3 R7 fifo read");
    @(negedge clk); chk("R4 irq released", irq_n, 1);
    par_read(2'd0, "R3 empty read zero");
    b = DW'($urandom);
    par_write(2'd2, b);
    chk("R6 ctrl output", ctrl, b);
    par_read(2'd2, "R6 ctrl readback");
    par_write(2'd3, 8'hA5);
    par_read(2'd3, "R6 reserved zero");
    b = DW'($urandom);
    par_write(2'd0, b);
    chk("R5 in_valid", in_valid, 1);
    chk("R5 R7 in_data", in_data, b);
    par_write(2'd0, ~b);
    chk("R5 dropped write", in_data, b);
    par_read(2'd1, "R6 status in full");
    @(negedge clk); in_ready = 1;
    @(negedge clk); in_ready = 0; in_full_m = 0;
    @(negedge clk); chk("R5 accepted", in_valid, 0);
    for (int k = 0; k < DEPTH + 1; k++) push(DW'($urandom));
    chk("R3 out_ready full", out_ready, 0);
    par_read(2'd0, "R3 head after full");
    par_read(2'd0, "R3 second");

    // R11: push coincident with pop (count 2)
    nb = DW'($urandom);
    @(negedge clk); addr0_sck = 0; addr1_sdi = 0; cs_n = 0; rd_n_rw = 0;
    @(negedge clk);
    @(negedge clk); out_valid = 1; out_data = nb;
    @(negedge clk); out_valid = 0;
    repeat (4) @(negedge clk);
    b = q.pop_front(); q.push_back(nb);
    chk("R11 popped head", bus_d_o, b);
    cs_n = 1; rd_n_rw = 1;
    repeat (H) @(negedge clk);
    for (int k = 0; k < 2; k++) par_read(2'd0, "R11 order");
    @(negedge clk); chk("R11 drained irq", irq_n, 1);

    // Motorola mode, strap 100
    do_reset(3'b100);
    chk("R1 R2 moto irq_n", irq_n, 1);
    b = DW'($urandom);
    push(b);
    par_read(2'd0, "R1 R8 moto read");
    b = DW'($urandom);
    par_write(2'd2, b);
    chk("R8 moto ctrl write", ctrl, b);
    par_read(2'd2, "R8 moto ctrl read");

    // SPI mode, strap 001
    do_reset(3'b001);
    chk("R2 spi sdo_oe", sdo_oe, 0);
    b = DW'($urandom);
    spi_xfer(0, 2'd2, b, "R9 spi write ctrl");
    chk("R1 R9 spi ctrl", ctrl, b);
    spi_xfer(1, 2'd2, 8'h00, "R9 spi read ctrl");
    push(DW'($urandom)); push(DW'($urandom));
    spi_xfer(1, 2'd1, 8'h00, "R9 spi status");
    // parallel strobe attempt in SPI mode
    @(negedge clk); cs_n = 0; rd_n_rw = 0; wr_n_ds = 0; bus_d_i = 8'h3C;
    repeat (H) @(negedge clk);
    chk("R10 no bus drive", bus_d_oe, 0);
    cs_n = 1; rd_n_rw = 1; wr_n_ds = 1;
    repeat (H) @(negedge clk);
    chk("R10 ctrl untouched", ctrl, ctrl_m);
    chk("R10 in_valid untouched", in_valid, 0);
    spi_xfer(1, 2'd0, 8'h00, "R9 spi fifo read 1");
    spi_xfer(1, 2'd0, 8'h00, "R9 spi fifo read 2");
    b = DW'($urandom);
    spi_xfer(0, 2'd0, b, "R9 spi data write");
    chk("R5 R9 spi in_data", in_data, b);
    @(negedge clk); chk("R4 spi irq released", irq_n, 1);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule